// File: doc/BRIEF.md
# Register Rename Unit with History Rollback

This block renames the register operands of one instruction per request in an out-of-order core. It holds a map from architectural to physical registers, a queue of free physical registers, a ready bit for each physical register, and a history that records every destination remapping along with the instruction's sequence number. Each accepted request returns the physical registers of two sources and their ready bits. If the instruction has a destination, the request also returns a newly allocated physical register and the physical register it replaces.

Recovery walks the history without checkpoints. A squash removes entries from the newest end and restores the map from each one. A commit removes entries from the oldest end and releases the replaced registers. Each walk handles one entry per cycle, and the block raises `busy` while a walk is in progress. An execution stage marks a physical register ready through the writeback set port.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i and every ready bit is set. The free queue holds physical registers NUM_ARCH to NUM_PHYS-1, handed out in ascending order. `busy`, `rsp_ok` and `rsp_stall` are low.
- R2: Response outputs are registered and valid in the cycle after the request. Each source returns its current mapping. Its ready bit is the scoreboard bit of that physical register, or 1 when `wb_valid` names that register in the request cycle.
- R3: An accepted request with `req_dst_valid`=1 does four things. It takes the head of the free queue as `rsp_dst_phys`, with freed registers going to the tail in first-in first-out order. It returns the prior mapping as `rsp_old_phys`. It remaps the destination and clears the new register's ready bit. It adds a history entry (sequence, architectural, new, previous) at the newest end. When the request has no destination, both outputs read 0.
- R4: The destination count is `req_dst_valid`, either 0 or 1. A request whose destination count exceeds the number of free registers is refused: `rsp_stall`=1, `rsp_ok`=0, and no state changes. A request with no destination is accepted even when the free queue is empty.
- R5: A request is ignored when `busy` is high or `squash_valid` is high in the same cycle. Nothing changes, and both `rsp_ok` and `rsp_stall` read 0.
- R6: A squash removes history entries, newest first, while their sequence number is greater than `squash_seq`. Each removal restores the map entry to the previous physical register and returns the new one to the free queue.
- R7: A commit removes history entries, oldest first, while their sequence number is at most `commit_seq`. Each removal returns the previous physical register to the free queue.
- R8: A commit whose oldest history entry is newer than `commit_seq` changes nothing, and neither does a walk on an empty history. Either walk then ends one cycle after it starts.
- R9: `commit_seq` is acted on only when it is non-zero, `busy` is low, and `squash_valid` is low. A squash overrides a commit walk that is under way. Commits are cumulative, so a skipped commit is covered by a later one.
- R10: A walk removes one entry per clock edge. `busy` rises in the cycle after the command and stays high for the number of removals plus one cycle. The free count plus the history count always equals NUM_PHYS-NUM_ARCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Rename request |
| req_seq | input | SEQ_W | Request sequence number |
| req_src0 | input | AW | First source architectural register |
| req_src1 | input | AW | Second source architectural register |
| req_dst_valid | input | 1 | Instruction has a destination |
| req_dst | input | AW | Destination architectural register |
| commit_seq | input | SEQ_W | Youngest committed sequence number, 0 for none |
| squash_valid | input | 1 | Squash command |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| wb_valid | input | 1 | Set a ready bit |
| wb_phys | input | PW | Physical register made ready |
| busy | output | 1 | A walk is in progress |
| rsp_ok | output | 1 | Previous request accepted |
| rsp_stall | output | 1 | Previous request refused for lack of registers |
| rsp_src0_phys | output | PW | First source physical register |
| rsp_src0_rdy | output | 1 | First source ready |
| rsp_src1_phys | output | PW | Second source physical register |
| rsp_src1_rdy | output | 1 | Second source ready |
| rsp_dst_phys | output | PW | Newly allocated physical register |
| rsp_old_phys | output | PW | Physical register replaced |

## Verification
The bench first runs a chain of dependent renames in which both sources name the same register, a source names the current destination, and an instruction has no destination. This shows that lookups read the map before it is updated and that the same-cycle writeback bypass works. Squashes of one and of two entries are followed by lookups of the restored registers, which shows newest-first undo and the order in which registers return to the free queue. Commits are tried in four forms: a real commit, a commit older than the oldest entry, a zero commit, and a commit in the same cycle as a squash. A later squash tells these apart, because it restores different mappings depending on which entries were still present. Draining the free queue tests the stall and its exemption for requests with no destination, and a final full commit shows which register is released first.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SQUASH = 2'd1,
    ST_COMMIT = 2'd2
  } rn_state_e;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd0_arch,
  input  logic [AW-1:0] rd1_arch,
  input  logic [AW-1:0] rd2_arch,
  output logic [PW-1:0] rd0_phys,
  output logic [PW-1:0] rd1_phys,
  output logic [PW-1:0] rd2_phys,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_arch,
  input  logic [PW-1:0] wr_phys
);
  logic [PW-1:0] map_q [NUM_ARCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PW'(i);
    end else if (wr_en) begin
      map_q[wr_arch] <= wr_phys;
    end
  end

  assign rd0_phys = map_q[rd0_arch];
  assign rd1_phys = map_q[rd1_arch];
  assign rd2_phys = map_q[rd2_arch];
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int FREE_N = NUM_PHYS - NUM_ARCH,
  localparam int IW = (FREE_N > 1) ? $clog2(FREE_N) : 1,
  localparam int CW = $clog2(FREE_N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  output logic [PW-1:0] head_phys,
  input  logic          push,
  input  logic [PW-1:0] push_phys,
  output logic [CW-1:0] count
);
  logic [PW-1:0] slot_q [FREE_N];
  logic [IW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    return (p == IW'(FREE_N - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < FREE_N; i++) slot_q[i] <= PW'(NUM_ARCH + i);
    end else if (push) begin
      slot_q[wr_q] <= push_phys;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CW'(FREE_N);
    end else begin
      if (pop)  rd_q <= bump(rd_q);
      if (push) wr_q <= bump(wr_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_phys = slot_q[rd_q];
  assign count     = cnt_q;
endmodule

// File: rtl/rn_scoreboard.sv
module rn_scoreboard #(
  parameter int NUM_PHYS = 16,
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [PW-1:0] set_phys,
  input  logic          clr_en,
  input  logic [PW-1:0] clr_phys,
  input  logic [PW-1:0] rd0_phys,
  input  logic [PW-1:0] rd1_phys,
  output logic          rd0_rdy,
  output logic          rd1_rdy
);
  logic [NUM_PHYS-1:0] rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q <= '1;
    end else begin
      if (set_en) rdy_q[set_phys] <= 1'b1;
      if (clr_en) rdy_q[clr_phys] <= 1'b0;
    end
  end

  assign rd0_rdy = rdy_q[rd0_phys] | (set_en && set_phys == rd0_phys);
  assign rd1_rdy = rdy_q[rd1_phys] | (set_en && set_phys == rd1_phys);
endmodule

// File: rtl/rn_history.sv
module rn_history #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int SEQ_W = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic [AW-1:0]    push_arch,
  input  logic [PW-1:0]    push_new,
  input  logic [PW-1:0]    push_prev,
  input  logic             pop_newest,
  input  logic             pop_oldest,
  output logic [SEQ_W-1:0] new_seq,
  output logic [AW-1:0]    new_arch,
  output logic [PW-1:0]    new_phys,
  output logic [PW-1:0]    new_prev,
  output logic [SEQ_W-1:0] old_seq,
  output logic [PW-1:0]    old_prev,
  output logic [CW-1:0]    count
);
  logic [SEQ_W-1:0] seq_mem  [DEPTH];
  logic [AW-1:0]    arch_mem [DEPTH];
  logic [PW-1:0]    nphy_mem [DEPTH];
  logic [PW-1:0]    pphy_mem [DEPTH];
  logic [IW-1:0]    oldest_q, wr_q, newest_idx;
  logic [CW-1:0]    cnt_q;

  function automatic logic [IW-1:0] inc(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [IW-1:0] dec(input logic [IW-1:0] p);
    return (p == '0) ? IW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign newest_idx = dec(wr_q);

  always_ff @(posedge clk) begin
    if (push) begin
      seq_mem[wr_q]  <= push_seq;
      arch_mem[wr_q] <= push_arch;
      nphy_mem[wr_q] <= push_new;
      pphy_mem[wr_q] <= push_prev;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oldest_q <= '0;
      wr_q     <= '0;
      cnt_q    <= '0;
    end else if (push) begin
      wr_q  <= inc(wr_q);
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_newest) begin
      wr_q  <= newest_idx;
      cnt_q <= cnt_q - 1'b1;
    end else if (pop_oldest) begin
      oldest_q <= inc(oldest_q);
      cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign new_seq  = seq_mem[newest_idx];
  assign new_arch = arch_mem[newest_idx];
  assign new_phys = nphy_mem[newest_idx];
  assign new_prev = pphy_mem[newest_idx];
  assign old_seq  = seq_mem[oldest_q];
  assign old_prev = pphy_mem[oldest_q];
  assign count    = cnt_q;
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rn_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int SEQ_W = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int FREE_N = NUM_PHYS - NUM_ARCH,
  localparam int CW = $clog2(FREE_N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [SEQ_W-1:0] req_seq,
  input  logic [AW-1:0]    req_src0,
  input  logic [AW-1:0]    req_src1,
  input  logic             req_dst_valid,
  input  logic [AW-1:0]    req_dst,
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic             squash_valid,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic             wb_valid,
  input  logic [PW-1:0]    wb_phys,
  output logic             busy,
  output logic             rsp_ok,
  output logic             rsp_stall,
  output logic [PW-1:0]    rsp_src0_phys,
  output logic             rsp_src0_rdy,
  output logic [PW-1:0]    rsp_src1_phys,
  output logic             rsp_src1_rdy,
  output logic [PW-1:0]    rsp_dst_phys,
  output logic [PW-1:0]    rsp_old_phys
);
  rn_state_e        state;
  logic [SEQ_W-1:0] walk_seq;
  logic [CW-1:0]    free_cnt, hist_cnt;
  logic [PW-1:0]    free_head;
  logic [PW-1:0]    s0_phys, s1_phys, d_prev;
  logic             s0_rdy, s1_rdy;
  logic [SEQ_W-1:0] h_new_seq, h_old_seq;
  logic [AW-1:0]    h_new_arch;
  logic [PW-1:0]    h_new_phys, h_new_prev, h_old_prev;
  logic             take, short, accept, alloc, sq_pop, cm_pop;
  logic             map_we, fl_push;
  logic [AW-1:0]    map_wa;
  logic [PW-1:0]    map_wd, fl_pd;

  assign take   = req_valid && (state == ST_IDLE) && !squash_valid;
  assign short  = req_dst_valid && (free_cnt == '0);
  assign accept = take && !short;
  assign alloc  = accept && req_dst_valid;
  assign sq_pop = (state == ST_SQUASH) && !squash_valid && (hist_cnt != '0)
                  && (h_new_seq > walk_seq);
  assign cm_pop = (state == ST_COMMIT) && !squash_valid && (hist_cnt != '0)
                  && (h_old_seq <= walk_seq);

  always_comb begin
    map_we = alloc || sq_pop;
    map_wa = alloc ? req_dst   : h_new_arch;
    map_wd = alloc ? free_head : h_new_prev;
    fl_push = sq_pop || cm_pop;
    fl_pd   = sq_pop ? h_new_phys : h_old_prev;
  end

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk(clk), .rst(rst),
    .rd0_arch(req_src0), .rd1_arch(req_src1), .rd2_arch(req_dst),
    .rd0_phys(s0_phys), .rd1_phys(s1_phys), .rd2_phys(d_prev),
    .wr_en(map_we), .wr_arch(map_wa), .wr_phys(map_wd)
  );

  rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk(clk), .rst(rst),
    .pop(alloc), .head_phys(free_head),
    .push(fl_push), .push_phys(fl_pd),
    .count(free_cnt)
  );

  rn_scoreboard #(.NUM_PHYS(NUM_PHYS)) u_sb (
    .clk(clk), .rst(rst),
    .set_en(wb_valid), .set_phys(wb_phys),
    .clr_en(alloc), .clr_phys(free_head),
    .rd0_phys(s0_phys), .rd1_phys(s1_phys),
    .rd0_rdy(s0_rdy), .rd1_rdy(s1_rdy)
  );

  rn_history #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .SEQ_W(SEQ_W)) u_hist (
    .clk(clk), .rst(rst),
    .push(alloc), .push_seq(req_seq), .push_arch(req_dst),
    .push_new(free_head), .push_prev(d_prev),
    .pop_newest(sq_pop), .pop_oldest(cm_pop),
    .new_seq(h_new_seq), .new_arch(h_new_arch),
    .new_phys(h_new_phys), .new_prev(h_new_prev),
    .old_seq(h_old_seq), .old_prev(h_old_prev),
    .count(hist_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      walk_seq <= '0;
    end else if (squash_valid) begin
      state    <= ST_SQUASH;
      walk_seq <= squash_seq;
    end else begin
      case (state)
        ST_IDLE: if (commit_seq != '0) begin
          state    <= ST_COMMIT;
          walk_seq <= commit_seq;
        end
        ST_SQUASH: if (!sq_pop) state <= ST_IDLE;
        ST_COMMIT: if (!cm_pop) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ok        <= 1'b0;
      rsp_stall     <= 1'b0;
      rsp_src0_phys <= '0;
      rsp_src0_rdy  <= 1'b0;
      rsp_src1_phys <= '0;
      rsp_src1_rdy  <= 1'b0;
      rsp_dst_phys  <= '0;
      rsp_old_phys  <= '0;
    end else begin
      rsp_ok        <= accept;
      rsp_stall     <= take && short;
      rsp_src0_phys <= s0_phys;
      rsp_src0_rdy  <= s0_rdy;
      rsp_src1_phys <= s1_phys;
      rsp_src1_rdy  <= s1_rdy;
      rsp_dst_phys  <= alloc ? free_head : '0;
      rsp_old_phys  <= alloc ? d_prev : '0;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int FREE_N = NUM_PHYS - NUM_ARCH,
  localparam int CW = $clog2(FREE_N + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_dst_valid,
  input logic          squash_valid,
  input logic          busy,
  input logic          rsp_ok,
  input logic          rsp_stall,
  input logic [CW-1:0] free_cnt,
  input logic [CW-1:0] hist_cnt
);
  a_r10_conserve: assert property (@(posedge clk) disable iff (rst)
    (32'(free_cnt) + 32'(hist_cnt)) == FREE_N);

  a_r4_stall_when_empty: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_dst_valid && !busy && !squash_valid && free_cnt == '0)
    |=> (rsp_stall && !rsp_ok));

  a_r5_ignore_busy: assert property (@(posedge clk) disable iff (rst)
    (busy || squash_valid) |=> (!rsp_ok && !rsp_stall));

  a_r9_squash_wins: assert property (@(posedge clk) disable iff (rst)
    squash_valid |=> busy);

  a_r3_history_push: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_dst_valid && !busy && !squash_valid && free_cnt != '0)
    |=> (hist_cnt == $past(hist_cnt) + 1'b1));

  a_r4_ok_stall_excl: assert property (@(posedge clk) disable iff (rst)
    !(rsp_ok && rsp_stall));
endmodule

bind rename_unit rename_unit_chk #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_dst_valid(req_dst_valid),
  .squash_valid(squash_valid), .busy(busy), .rsp_ok(rsp_ok),
  .rsp_stall(rsp_stall), .free_cnt(free_cnt), .hist_cnt(hist_cnt)
);

// File: tb/rename_unit_bench.sv
module rename_unit_bench;
  localparam int NA = 8, NP = 16, SW = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_dst_valid = 0, squash_valid = 0, wb_valid = 0;
  logic [SW-1:0] req_seq = 0, commit_seq = 0, squash_seq = 0;
  logic [2:0] req_src0 = 0, req_src1 = 0, req_dst = 0;
  logic [3:0] wb_phys = 0;
  logic busy, rsp_ok, rsp_stall, rsp_src0_rdy, rsp_src1_rdy;
  logic [3:0] rsp_src0_phys, rsp_src1_phys, rsp_dst_phys, rsp_old_phys;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rename_unit #(.NUM_ARCH(NA), .NUM_PHYS(NP), .SEQ_W(SW)) u_rename_unit (.*);

  typedef struct packed {
    logic [15:0] seq; logic [2:0] s0; logic [2:0] s1; logic dv; logic [2:0] d;
    logic wbv; logic [3:0] wbp;
    logic ok; logic st; logic [3:0] p0; logic r0; logic [3:0] p1; logic r1;
    logic [3:0] pd; logic [3:0] old;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{16'd1, 3'd1, 3'd2, 1'b1, 3'd3, 1'b0, 4'd0,  1'b1, 1'b0, 4'd1,  1'b1, 4'd2,  1'b1, 4'd8,  4'd3},
    '{16'd2, 3'd3, 3'd3, 1'b1, 3'd3, 1'b0, 4'd0,  1'b1, 1'b0, 4'd8,  1'b0, 4'd8,  1'b0, 4'd9,  4'd8},
    '{16'd3, 3'd3, 3'd0, 1'b1, 3'd5, 1'b0, 4'd0,  1'b1, 1'b0, 4'd9,  1'b0, 4'd0,  1'b1, 4'd10, 4'd5},
    '{16'd4, 3'd5, 3'd7, 1'b0, 3'd0, 1'b0, 4'd0,  1'b1, 1'b0, 4'd10, 1'b0, 4'd7,  1'b1, 4'd0,  4'd0},
    '{16'd5, 3'd3, 3'd5, 1'b0, 3'd0, 1'b1, 4'd10, 1'b1, 1'b0, 4'd9,  1'b0, 4'd10, 1'b1, 4'd0,  4'd0},
    '{16'd6, 3'd5, 3'd1, 1'b1, 3'd1, 1'b0, 4'd0,  1'b1, 1'b0, 4'd10, 1'b1, 4'd1,  1'b1, 4'd11, 4'd1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rn(input int seq, input int s0, input int s1, input bit dv,
                    input int d, input bit wbv, input int wbp);
    req_valid = 1; req_seq = SW'(seq); req_src0 = 3'(s0); req_src1 = 3'(s1);
    req_dst_valid = dv; req_dst = 3'(d); wb_valid = wbv; wb_phys = 4'(wbp);
    @(negedge clk);
    req_valid = 0; req_dst_valid = 0; wb_valid = 0;
  endtask

  task automatic squash(input int s);
    squash_valid = 1; squash_seq = SW'(s);
    @(negedge clk);
    squash_valid = 0;
  endtask

  task automatic commit(input int s);
    commit_seq = SW'(s);
    @(negedge clk);
    commit_seq = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 rsp_ok after reset", rsp_ok, 0);
    chk("R1 rsp_stall after reset", rsp_stall, 0);

    // R8: squash on empty history has no effect, ends in one cycle
    squash(0);
    wait_idle(n);
    chk("R8 empty squash busy cycles", n, 1);

    // R1 R2 R3: vector table
    foreach (VEC[i]) begin
      rn(VEC[i].seq, VEC[i].s0, VEC[i].s1, VEC[i].dv, VEC[i].d, VEC[i].wbv, VEC[i].wbp);
      chk($sformatf("R3 ok v%0d", i), rsp_ok, VEC[i].ok);
      chk($sformatf("R4 stall v%0d", i), rsp_stall, VEC[i].st);
      chk($sformatf("R2 src0 v%0d", i), rsp_src0_phys, VEC[i].p0);
      chk($sformatf("R2 rdy0 v%0d", i), rsp_src0_rdy, VEC[i].r0);
      chk($sformatf("R2 src1 v%0d", i), rsp_src1_phys, VEC[i].p1);
      chk($sformatf("R2 rdy1 v%0d", i), rsp_src1_rdy, VEC[i].r1);
      chk($sformatf("R1 R3 dst v%0d", i), rsp_dst_phys, VEC[i].pd);
      chk($sformatf("R3 old v%0d", i), rsp_old_phys, VEC[i].old);
    end

    // R6 R10: squash 3 removes only seq 6
    squash(3);
    wait_idle(n);
    chk("R10 squash one entry busy cycles", n, 2);
    rn(7, 1, 5, 1, 2, 0, 0);
    chk("R6 restored map of arch 1", rsp_src0_phys, 1);
    chk("R6 arch 5 kept", rsp_src1_phys, 10);
    chk("R3 fifo order after squash", rsp_dst_phys, 12);
    chk("R3 old phys", rsp_old_phys, 2);

    // R7 R5: commit 2, request during walk ignored
    commit(2);
    rn(50, 4, 4, 1, 4, 0, 0);
    chk("R5 ignored while busy ok", rsp_ok, 0);
    chk("R5 ignored while busy stall", rsp_stall, 0);
    wait_idle(n);

    // R8: commit older than oldest entry does nothing
    commit(2);
    wait_idle(n);
    chk("R8 stale commit busy cycles", n, 1);

    // R9: zero commit not acted on
    commit(0);
    chk("R9 zero commit no busy", busy, 0);

    rn(8, 4, 4, 0, 0, 0, 0);
    chk("R5 ignored request left arch 4", rsp_src0_phys, 4);

    // R9: commit and squash together, squash wins
    squash_valid = 1; squash_seq = 7; commit_seq = 7;
    @(negedge clk);
    squash_valid = 0; commit_seq = 0;
    wait_idle(n);

    // R6 R9: squash 2 undoes seq 7 and seq 3 (still present)
    squash(2);
    wait_idle(n);
    chk("R10 squash two entries busy cycles", n, 3);
    rn(9, 5, 2, 1, 6, 0, 0);
    chk("R6 R9 arch 5 restored", rsp_src0_phys, 5);
    chk("R6 arch 2 restored", rsp_src1_phys, 2);
    chk("R7 R3 free order", rsp_dst_phys, 13);

    // R3: drain, freed registers return in FIFO order
    begin
      int exp_pd [7] = '{14, 15, 11, 3, 8, 12, 10};
      int prev = 7;
      for (int i = 0; i < 7; i++) begin
        rn(10 + i, 7, 7, 1, 7, 0, 0);
        chk($sformatf("R3 drain dst %0d", i), rsp_dst_phys, exp_pd[i]);
        chk($sformatf("R3 drain old %0d", i), rsp_old_phys, prev);
        chk($sformatf("R2 drain rdy %0d", i), rsp_src0_rdy, (i == 0) ? 1 : 0);
        prev = exp_pd[i];
      end
    end

    // R4: stall on empty free list, no-dest still accepted
    rn(17, 0, 0, 1, 1, 0, 0);
    chk("R4 stall raised", rsp_stall, 1);
    chk("R4 refused", rsp_ok, 0);
    rn(18, 7, 1, 0, 0, 0, 0);
    chk("R4 no-dest accepted", rsp_ok, 1);
    chk("R4 refused left arch 1", rsp_src1_phys, 1);
    chk("R4 map of arch 7", rsp_src0_phys, 10);

    // R7 R10: full commit releases prev registers oldest first
    commit(100);
    wait_idle(n);
    chk("R10 commit eight entries busy cycles", n, 9);
    rn(101, 0, 0, 1, 0, 0, 0);
    chk("R7 oldest prev freed first", rsp_dst_phys, 6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule